// File: doc/BRIEF.md
# Serial Gain Command Writer

This block programs a two-channel programmable-gain front end over a four-wire serial link, acting as the bus master. User logic presents two gain codes, one per channel, on a valid/ready request port. The block captures both codes when the request is accepted and builds one command frame from them. It lowers chip select, shifts the frame out on MOSI against a divided serial clock, and raises chip select again. During the same frame it shifts in the byte the amplifier returns on its data output. That byte holds the gain settings the amplifier had before this command.

Back-pressure on the request port works as follows. `cmd_ready` is high only while the block is idle. A request is taken on the first clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, `cmd_valid` is ignored, and the requester may hold it or drop it. There is no queue. The returned byte has no back-pressure: `done` is high for a single cycle, and `echo_data` stays valid from that cycle until the next frame begins.

Serial timing is set by the parameter `HALF_DIV`, which gives the number of system clocks in each half period of SCK. Choose it so that one half period is at least 50 ns at the system clock in use.

Top module: `gain_spi_writer`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0, `done` is 0 and `cmd_ready` is 1.
- R2: The frame is 8 bits long and is sent most significant bit first. The frame is {gain_b[3:0], gain_a[3:0]}, so channel B's bit 3 goes first and channel A's bit 0 goes last. The amplifier samples MOSI on each rising SCK edge.
- R3: Each accepted request produces exactly one low period of `spi_cs_n`, and that period contains exactly 8 rising edges of SCK.
- R4: SCK stays low whenever `spi_cs_n` is high. MOSI changes only while SCK is low, and it is stable for at least 30 ns before each rising edge.
- R5: Every high phase and every low phase of SCK inside a frame lasts at least `HALF_DIV` system clocks. That is at least 50 ns with the default settings.
- R6: The amplifier changes its output bit on each falling SCK edge. The block samples that output just before each falling edge. The first bit sampled becomes bit 7 of `echo_data`, which is presented together with `done`.
- R7: `busy` is high from the cycle after acceptance until `spi_cs_n` rises. `done` is a one-cycle pulse in the same cycle that `spi_cs_n` rises.
- R8: `cmd_valid` asserted while `busy` is high is ignored. It starts no frame, and the frame in progress keeps its bits.
- R9: The gain inputs are captured when a request is accepted. Changing them during a frame does not change the bits being sent.
- R10: At least 30 ns pass between the fall of `spi_cs_n` and the first rising SCK edge. `spi_cs_n` rises at least one SCK half period after the last rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Request accepted when high together with cmd_valid |
| gain_a | input | GAIN_W | Gain code for channel A |
| gain_b | input | GAIN_W | Gain code for channel B (sent first) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| echo_data | output | 2*GAIN_W | Previous settings returned by the amplifier |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the amplifier |
| spi_miso | input | 1 | Serial data from the amplifier |

## Verification
The bench builds the block with `GAIN_W` = 4 and `HALF_DIV` = 7 on an 8 ns clock. That makes each SCK half period 56 ns, only a few nanoseconds above the 50 ns floor, so the phase-width, setup and hold checks are made in nanoseconds close to their limits. The amplifier model changes its output 80 ns after each falling edge, just inside the 85 ns it is allowed. A block that sampled on the rising edge would therefore read stale bits. Frames are issued back to back, with requests held during busy periods and gain inputs changed in the middle of frames.

// File: rtl/gain_spi_pkg.sv
`timescale 1ns/1ps
package gain_spi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } wr_state_t;
endpackage

// File: rtl/gain_spi_divider.sv
`timescale 1ns/1ps
module gain_spi_divider #(
  parameter int HALF_DIV = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R5
  tick_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(run));
endmodule

// File: rtl/gain_spi_frame.sv
`timescale 1ns/1ps
module gain_spi_frame #(
  parameter int GAIN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [GAIN_W-1:0]     gain_a,
  input  logic [GAIN_W-1:0]     gain_b,
  input  logic                  step,
  input  logic                  miso,
  output logic                  mosi,
  output logic                  last,
  output logic [2*GAIN_W-1:0]   echo
);
  localparam int FW = 2 * GAIN_W;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] tx_q, rx_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      tx_q  <= {gain_b, gain_a};
      cnt_q <= '0;
    end else if (step) begin
      tx_q  <= {tx_q[FW-2:0], 1'b0};
      rx_q  <= {rx_q[FW-2:0], miso};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mosi = tx_q[FW-1];
  assign last = (cnt_q == CW'(FW - 1));
  assign echo = rx_q;

  // R3
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FW));
endmodule

// File: rtl/gain_spi_writer.sv
`timescale 1ns/1ps
module gain_spi_writer
  import gain_spi_pkg::*;
#(
  parameter int GAIN_W   = 4,
  parameter int HALF_DIV = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [GAIN_W-1:0]    gain_a,
  input  logic [GAIN_W-1:0]    gain_b,
  output logic                 busy,
  output logic                 done,
  output logic [2*GAIN_W-1:0]  echo_data,
  output logic                 spi_cs_n,
  output logic                 spi_sck,
  output logic                 spi_mosi,
  input  logic                 spi_miso
);
  localparam int PW = $clog2(HALF_DIV + 1) + 1;

  wr_state_t state_q;
  logic      tick, last_bit, accept, fall;

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign fall      = (state_q == ST_SHIFT) && tick && spi_sck;

  gain_spi_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  gain_spi_frame #(.GAIN_W(GAIN_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(accept), .gain_a(gain_a), .gain_b(gain_b),
    .step(fall), .miso(spi_miso), .mosi(spi_mosi), .last(last_bit), .echo(echo_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      spi_cs_n <= 1'b1;
      spi_sck  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_LEAD;
          spi_cs_n <= 1'b0;
        end
        ST_LEAD: if (tick) begin
          spi_sck <= 1'b1;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (spi_sck) begin
            spi_sck <= 1'b0;
            if (last_bit) state_q <= ST_TAIL;
          end else begin
            spi_sck <= 1'b1;
          end
        end
        ST_TAIL: if (tick) begin
          spi_cs_n <= 1'b1;
          done     <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // phase-length counter used only by the R5 check below
  logic          sck_q;
  logic [PW-1:0] ph_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      ph_q  <= '0;
    end else begin
      sck_q <= spi_sck;
      if (spi_sck != sck_q)            ph_q <= PW'(1);
      else if (ph_q < PW'(HALF_DIV))   ph_q <= ph_q + 1'b1;
    end
  end

  // R5
  sck_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck != sck_q) |-> (ph_q >= PW'(HALF_DIV)));
  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  // R7
  done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(spi_cs_n));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(cmd_ready));
endmodule

// File: tb/sim_gain_spi_writer.sv
`timescale 1ns/1ps
module sim_gain_spi_writer;
  localparam int  GW = 4;
  localparam int  HD = 7;
  localparam real HALF_NS = HD * 8.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [GW-1:0] gain_a = '0, gain_b = '0;
  logic busy, done, spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;
  logic [2*GW-1:0] echo_data;

  always #4 clk = ~clk;

  gain_spi_writer #(.GAIN_W(GW), .HALF_DIV(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .gain_a(gain_a), .gain_b(gain_b), .busy(busy), .done(done),
    .echo_data(echo_data), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, errors = 0;
  logic [7:0] exp_cmd[$];
  logic [7:0] exp_echo[$];
  logic [7:0] exp_prev = 8'hC3;
  int sent = 0, cs_falls = 0, done_cnt = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // amplifier model
  logic [7:0] prev = 8'hC3, shadow, rx;
  int  oidx, rises;
  bit  in_frame = 0;
  realtime t_csfall, t_rise, t_fall, t_mosi;

  always @(negedge spi_cs_n) begin
    in_frame = 1; cs_falls++; rises = 0; shadow = prev; oidx = 7;
    t_csfall = $realtime;
    spi_miso = shadow[7];
  end
  always @(spi_mosi) begin
    t_mosi = $realtime;
    if (in_frame && rises > 0)  // R4 hold after rising edge
      chk(($realtime - t_rise) >= 30.0, "R4", "mosi hold ns", longint'($realtime - t_rise), 30);
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    rises++;
    rx = {rx[6:0], spi_mosi};
    chk(($realtime - t_mosi) >= 30.0, "R4", "mosi setup ns", longint'($realtime - t_mosi), 30);
    if (rises == 1)
      chk(($realtime - t_csfall) >= 30.0, "R10", "cs lead ns", longint'($realtime - t_csfall), 30);
    else
      chk(($realtime - t_fall) >= 50.0, "R5", "sck low ns", longint'($realtime - t_fall), 50);
    t_rise = $realtime;
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    chk(($realtime - t_rise) >= 50.0, "R5", "sck high ns", longint'($realtime - t_rise), 50);
    t_fall = $realtime;
    if (oidx > 0) begin
      oidx--;
      #80 spi_miso = shadow[oidx];
    end
  end
  always @(posedge spi_cs_n) if (in_frame) begin
    logic [7:0] e;
    in_frame = 0;
    chk(rises == 8, "R3", "rising edges per frame", rises, 8);
    chk(($realtime - t_rise) >= HALF_NS, "R10", "cs tail ns", longint'($realtime - t_rise), longint'(HALF_NS));
    if (exp_cmd.size() == 0) chk(0, "R8", "unexpected frame", rx, 0);
    else begin
      e = exp_cmd.pop_front();
      chk(rx == e, "R2,R9", "frame bits", rx, e);
    end
    prev = rx;
  end

  // result monitor
  always @(negedge clk) if (rst_n) begin
    if (done) begin
      logic [7:0] e;
      done_cnt++;
      chk(spi_cs_n && !busy && cmd_ready, "R7", "state at done", {spi_cs_n, busy, cmd_ready}, 3'b101);
      if (exp_echo.size() == 0) chk(0, "R7", "unexpected done", 1, 0);
      else begin
        e = exp_echo.pop_front();
        chk(echo_data == e, "R6", "echo byte", echo_data, e);
      end
    end else if (!spi_cs_n) begin
      chk(busy, "R7", "busy while cs low", busy, 1);
    end
  end

  task automatic send(input logic [3:0] b, input logic [3:0] a, input int hold_busy);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    gain_b = b; gain_a = a; cmd_valid = 1'b1;
    exp_cmd.push_back({b, a});
    exp_echo.push_back(exp_prev);
    exp_prev = {b, a};
    sent++;
    @(negedge clk);
    chk(busy && !cmd_ready, "R7", "busy after accept", busy, 1);
    gain_b = ~b; gain_a = ~a;   // R9: inputs change mid-frame
    if (hold_busy > 0) begin    // R8: request held while busy
      for (int i = 0; i < hold_busy; i++) @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(spi_cs_n == 1, "R1", "cs_n", spi_cs_n, 1);
    chk(spi_sck == 0, "R1", "sck", spi_sck, 0);
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(cmd_ready == 1, "R1", "cmd_ready", cmd_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(4'h1, 4'h1, 0);
    send(4'hF, 4'h0, 0);
    send(4'h0, 4'hF, 0);
    send(4'hA, 4'h5, 40);
    send(4'h6, 4'h3, 100);
    send(4'h7, 4'hE, 0);
    send(4'h8, 4'h1, 0);
    for (int i = 0; i < 3000 && (exp_echo.size() != 0 || busy); i++) @(negedge clk);
    repeat (20) @(negedge clk);
    // R8: held requests started nothing extra
    chk(cs_falls == sent, "R8", "frames started", cs_falls, sent);
    chk(done_cnt == sent, "R7", "done pulses", done_cnt, sent);
    chk(exp_echo.size() == 0, "R6", "pending echoes", exp_echo.size(), 0);
    chk(spi_cs_n && !spi_sck, "R4", "idle lines", {spi_cs_n, spi_sck}, 2'b10);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule